// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit CPU

This block forms the 16-bit address used by the long-reach operand forms of a small 8-bit processor. When the decoder gives it a start pulse, it takes several inputs and builds the address from them. The inputs are the selected addressing mode, the two bytes that follow the opcode, the B accumulator, the address of the next instruction and the register file. The result is either a memory operand address or, for jumps, the branch target. The address appears on a registered output together with a one-cycle valid pulse.

Three of the four modes are pure arithmetic and finish in one cycle:

- Direct mode uses the two instruction bytes as the address.
- Indexed mode adds B to that address.
- Relative mode adds a signed byte offset to the next-instruction address.

Relative mode can also carry a bit-test condition. If the condition fails, the output falls back to the next-instruction address.

Indirect mode fetches a pointer that is spread over two registers, low byte in Rn and high byte in Rn-1. The register file gives out one byte per read, with one cycle of latency. A small sequencer therefore issues both reads and then assembles the pointer.

Top module: `eff_addr_gen`

## Requirements
- R1: In reset and on the first cycle after it, `addr_valid`, `busy`, `rf_rd_en`, `take_branch` are 0 and `addr_out` is 0x0000.
- R2: Mode 2'b00 (direct). On the clock edge after an accepted start, `addr_valid` pulses and `addr_out` = {`opnd_hi`, `opnd_lo`}.
- R3: Mode 2'b10 (indexed). On the clock edge after an accepted start, `addr_out` = {`opnd_hi`, `opnd_lo`} + zero-extended `b_reg`. The carry from the low byte enters the high byte, and the sum wraps modulo 2^16.
- R4: Mode 2'b01 (indirect). The block reads register `reg_idx` on the edge after start and reads `reg_idx`-1 on the next edge. Each read returns its data one cycle later. `addr_valid` rises on the third edge after the accepting edge, with `addr_out` = {data of Rn-1, data of Rn}. `busy` is high from the accepting edge until that result.
- R5: The indirect high-byte index is computed modulo 128, so index 0 takes its high byte from register 127.
- R6: Mode 2'b11 (relative) with `br_kind` 2'b00 or 2'b11. `addr_out` = `next_pc` + sign-extended `opnd_lo`, modulo 2^16, and `take_branch` = 1, both one edge after start.
- R7: Relative with `br_kind` 2'b01 (jump-if-one). The branch is taken if (`tst_src` AND `tst_dst`) is nonzero. When taken, `addr_out` is the target and `take_branch` = 1. Otherwise `addr_out` = `next_pc` and `take_branch` = 0.
- R8: Relative with `br_kind` 2'b10 (jump-if-zero). The branch is taken if (`tst_src` AND NOT `tst_dst`) is nonzero, with the same outputs as R7.
- R9: A start while `busy` is high is ignored. It produces no valid pulse and does not change the pending result.
- R10: `addr_valid` lasts exactly one cycle. `addr_out` and `take_branch` hold their value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation |
| mode | input | 2 | 00 direct, 01 indirect, 10 indexed, 11 relative |
| br_kind | input | 2 | Relative condition: 00/11 always, 01 jump-if-one, 10 jump-if-zero |
| opnd_hi | input | 8 | First byte after the opcode (address high) |
| opnd_lo | input | 8 | Second byte after the opcode (address low, or relative offset) |
| reg_idx | input | 7 | Register holding the pointer low byte |
| b_reg | input | 8 | B register value for indexing |
| next_pc | input | 16 | Address of the following instruction |
| tst_src | input | 8 | Bit-test mask operand |
| tst_dst | input | 8 | Bit-test tested operand |
| rf_rd_data | input | 8 | Register-file read data, one cycle after the request |
| rf_rd_addr | output | 7 | Register-file read index |
| rf_rd_en | output | 1 | Register-file read request |
| addr_out | output | 16 | Effective address or branch target |
| addr_valid | output | 1 | One-cycle pulse marking a new result |
| take_branch | output | 1 | Relative branch taken |
| busy | output | 1 | Indirect sequence in progress |

## Verification
The bench aims at the carries and the wrap-around points, where each wrong implementation leaves a distinct mark:

- An index adder that drops the carry gives a high byte that is one too low.
- An offset that is not sign-extended sends a backward jump 256 bytes forward.
- A pointer index that wraps to 0xFF instead of 0x7F reads the wrong high register.

The bench also checks the two bit-test polarities, on operands that tell AND apart from AND-NOT. It checks the exact cycle of the indirect result, which exposes a byte swap or a miscounted read latency. A start given during the sequence must not slip in a spurious early valid pulse.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT   = 2'b00,
    AM_INDIRECT = 2'b01,
    AM_INDEXED  = 2'b10,
    AM_RELATIVE = 2'b11
  } amode_t;

  typedef enum logic [1:0] {
    BK_ALWAYS  = 2'b00,
    BK_ONE     = 2'b01,
    BK_ZERO    = 2'b10,
    BK_ALWAYS2 = 2'b11
  } bkind_t;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'b00,
    SQ_LO_REQ  = 2'b01,
    SQ_HI_REQ  = 2'b10,
    SQ_HI_WAIT = 2'b11
  } seq_t;
endpackage

// File: rtl/eag_bit_test.sv
module eag_bit_test #(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        kind,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  output logic              taken
);
  import eag_pkg::*;

  logic [DATA_W-1:0] ones_hit;
  logic [DATA_W-1:0] zeros_hit;

  assign ones_hit  = src & dst;
  assign zeros_hit = src & ~dst;

  always_comb begin
    case (bkind_t'(kind))
      BK_ONE:  taken = |ones_hit;
      BK_ZERO: taken = |zeros_hit;
      default: taken = 1'b1;
    endcase
  end
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] b_val,
  input  logic [ADDR_W-1:0] pc_next,
  input  logic              cond_ok,
  output logic [ADDR_W-1:0] addr,
  output logic              take
);
  import eag_pkg::*;

  localparam int EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] b_ext;
  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] rel_tgt;

  assign base    = {hi, lo};
  assign b_ext   = {{EXT_W{1'b0}}, b_val};
  assign off_ext = {{EXT_W{lo[DATA_W-1]}}, lo};
  assign rel_tgt = pc_next + off_ext;

  always_comb begin
    take = 1'b0;
    case (amode_t'(mode))
      AM_INDEXED:  addr = base + b_ext;
      AM_RELATIVE: begin
        take = cond_ok;
        addr = cond_ok ? rel_tgt : pc_next;
      end
      default:     addr = base;
    endcase
  end
endmodule

// File: rtl/eag_rf_seq.sv
module eag_rf_seq #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [IDX_W-1:0]      idx,
  input  logic [DATA_W-1:0]     rd_data,
  output logic [IDX_W-1:0]      rd_addr,
  output logic                  rd_en,
  output logic                  busy,
  output logic                  done,
  output logic [2*DATA_W-1:0]   ptr
);
  import eag_pkg::*;

  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  seq_t              state;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      idx_q   <= '0;
      lo_q    <= '0;
      rd_addr <= '0;
      rd_en   <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          rd_en <= 1'b0;
          if (go) begin
            idx_q   <= idx;
            rd_addr <= idx;
            rd_en   <= 1'b1;
            state   <= SQ_LO_REQ;
          end
        end
        SQ_LO_REQ: begin
          rd_addr <= idx_q - IDX_ONE;
          rd_en   <= 1'b1;
          state   <= SQ_HI_REQ;
        end
        SQ_HI_REQ: begin
          lo_q  <= rd_data;
          rd_en <= 1'b0;
          state <= SQ_HI_WAIT;
        end
        default: begin
          rd_en <= 1'b0;
          state <= SQ_IDLE;
        end
      endcase
    end
  end

  assign busy = (state != SQ_IDLE);
  assign done = (state == SQ_HI_WAIT);
  assign ptr  = {rd_data, lo_q};
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [1:0]        br_kind,
  input  logic [DATA_W-1:0] opnd_hi,
  input  logic [DATA_W-1:0] opnd_lo,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] b_reg,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [DATA_W-1:0] tst_src,
  input  logic [DATA_W-1:0] tst_dst,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic [IDX_W-1:0]  rf_rd_addr,
  output logic              rf_rd_en,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid,
  output logic              take_branch,
  output logic              busy
);
  import eag_pkg::*;

  logic              accept;
  logic              go_ind;
  logic              cond_ok;
  logic [ADDR_W-1:0] calc_addr;
  logic              calc_take;
  logic              seq_busy;
  logic              seq_done;
  logic [ADDR_W-1:0] seq_ptr;

  assign accept = start && !seq_busy;
  assign go_ind = accept && (amode_t'(mode) == AM_INDIRECT);

  eag_bit_test #(.DATA_W(DATA_W)) u_test (
    .kind (br_kind),
    .src  (tst_src),
    .dst  (tst_dst),
    .taken(cond_ok)
  );

  eag_addr_calc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_calc (
    .mode   (mode),
    .hi     (opnd_hi),
    .lo     (opnd_lo),
    .b_val  (b_reg),
    .pc_next(next_pc),
    .cond_ok(cond_ok),
    .addr   (calc_addr),
    .take   (calc_take)
  );

  eag_rf_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .go     (go_ind),
    .idx    (reg_idx),
    .rd_data(rf_rd_data),
    .rd_addr(rf_rd_addr),
    .rd_en  (rf_rd_en),
    .busy   (seq_busy),
    .done   (seq_done),
    .ptr    (seq_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out    <= '0;
      addr_valid  <= 1'b0;
      take_branch <= 1'b0;
    end else begin
      addr_valid <= 1'b0;
      if (seq_done) begin
        addr_out    <= seq_ptr;
        take_branch <= 1'b0;
        addr_valid  <= 1'b1;
      end else if (accept && !go_ind) begin
        addr_out    <= calc_addr;
        take_branch <= calc_take;
        addr_valid  <= 1'b1;
      end
    end
  end

  assign busy = seq_busy;
endmodule

// File: rtl/eff_addr_gen_chk.sv
module eff_addr_gen_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [1:0]        mode,
  input logic [DATA_W-1:0] opnd_hi,
  input logic [DATA_W-1:0] opnd_lo,
  input logic [DATA_W-1:0] b_reg,
  input logic [IDX_W-1:0]  rf_rd_addr,
  input logic              rf_rd_en,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_valid,
  input logic              busy
);
  localparam int EXT_W = ADDR_W - DATA_W;

  AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == 2'b00) |=> (addr_valid && addr_out == {$past(opnd_hi), $past(opnd_lo)})); // R2

  AST_INDEXED_ADDR: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == 2'b10) |=>
      (addr_valid && addr_out == ADDR_W'({$past(opnd_hi), $past(opnd_lo)} + {{EXT_W{1'b0}}, $past(b_reg)}))); // R3

  AST_PAIR_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (rf_rd_en && $past(rf_rd_en)) |-> (rf_rd_addr == IDX_W'($past(rf_rd_addr) - IDX_W'(1)))); // R5

  AST_IND_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == 2'b01) |=> (busy && !addr_valid)); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> !addr_valid); // R10

  AST_BUSY_NO_VALID_EARLY: assert property (@(posedge clk) disable iff (rst)
    (busy && rf_rd_en) |-> !addr_valid); // R9
endmodule

bind eff_addr_gen eff_addr_gen_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .mode      (mode),
  .opnd_hi   (opnd_hi),
  .opnd_lo   (opnd_lo),
  .b_reg     (b_reg),
  .rf_rd_addr(rf_rd_addr),
  .rf_rd_en  (rf_rd_en),
  .addr_out  (addr_out),
  .addr_valid(addr_valid),
  .busy      (busy)
);

// File: tb/eff_addr_gen_test.sv
module eff_addr_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [1:0]  br_kind = 2'b00;
  logic [7:0]  opnd_hi = '0;
  logic [7:0]  opnd_lo = '0;
  logic [6:0]  reg_idx = '0;
  logic [7:0]  b_reg = '0;
  logic [15:0] next_pc = '0;
  logic [7:0]  tst_src = '0;
  logic [7:0]  tst_dst = '0;
  logic [7:0]  rf_rd_data = '0;
  logic [6:0]  rf_rd_addr;
  logic        rf_rd_en;
  logic [15:0] addr_out;
  logic        addr_valid;
  logic        take_branch;
  logic        busy;

  logic [7:0] regs [128];
  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rf_rd_en) rf_rd_data <= regs[rf_rd_addr];

  eff_addr_gen uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .br_kind(br_kind),
    .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .reg_idx(reg_idx), .b_reg(b_reg),
    .next_pc(next_pc), .tst_src(tst_src), .tst_dst(tst_dst),
    .rf_rd_data(rf_rd_data), .rf_rd_addr(rf_rd_addr), .rf_rd_en(rf_rd_en),
    .addr_out(addr_out), .addr_valid(addr_valid), .take_branch(take_branch),
    .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Pulse start for one cycle; returns at the negedge after the accepting edge.
  task automatic fire(input logic [1:0] m);
    @(negedge clk);
    mode  = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", addr_valid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 rd_en", rf_rd_en, 0);
    chk("R1 take", take_branch, 0);
    chk("R1 addr", addr_out, 16'h0000);
  endtask

  task automatic t_direct(input logic [7:0] h, input logic [7:0] l);
    opnd_hi = h; opnd_lo = l;
    fire(2'b00);
    chk("R2 valid", addr_valid, 1);
    chk("R2 addr", addr_out, {h, l});
    @(negedge clk);
    chk("R10 pulse", addr_valid, 0);
    chk("R10 hold", addr_out, {h, l});
  endtask

  task automatic t_indexed(input logic [7:0] h, input logic [7:0] l, input logic [7:0] b, input logic [15:0] exp);
    opnd_hi = h; opnd_lo = l; b_reg = b;
    fire(2'b10);
    chk("R3 valid", addr_valid, 1);
    chk("R3 addr", addr_out, exp);
  endtask

  task automatic t_indirect(input logic [6:0] n, input logic [7:0] lo_v, input logic [7:0] hi_v, input string req);
    logic [6:0] up;
    up = n - 7'd1;
    regs[n]  = lo_v;
    regs[up] = hi_v;
    regs[(n + 7'd1) & 7'h7f] = 8'hEE;
    reg_idx = n;
    fire(2'b01);
    chk({req, " busy"}, busy, 1);
    chk({req, " rd first"}, {rf_rd_en, rf_rd_addr}, {1'b1, n});
    @(negedge clk);
    chk({req, " rd second"}, {rf_rd_en, rf_rd_addr}, {1'b1, up});
    chk({req, " early"}, addr_valid, 0);
    @(negedge clk);
    chk({req, " early"}, addr_valid, 0);
    @(negedge clk);
    chk({req, " valid"}, addr_valid, 1);
    chk({req, " addr"}, addr_out, {hi_v, lo_v});
    @(negedge clk);
    chk({req, " idle"}, busy, 0);
  endtask

  task automatic t_rel(input logic [1:0] k, input logic [15:0] pc, input logic [7:0] off,
                       input logic [7:0] s, input logic [7:0] d,
                       input logic [15:0] exp, input logic tk, input string req);
    br_kind = k; next_pc = pc; opnd_lo = off; tst_src = s; tst_dst = d;
    fire(2'b11);
    chk({req, " valid"}, addr_valid, 1);
    chk({req, " addr"}, addr_out, exp);
    chk({req, " take"}, take_branch, tk);
  endtask

  task automatic t_busy_ignore;
    regs[7'd20] = 8'h5A;
    regs[7'd19] = 8'hC3;
    reg_idx = 7'd20;
    fire(2'b01);
    // second start in direct mode while busy; must be dropped (R9)
    opnd_hi = 8'h11; opnd_lo = 8'h22;
    mode = 2'b00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 no early valid", addr_valid, 0);
    @(negedge clk);
    chk("R9 no early valid", addr_valid, 0);
    @(negedge clk);
    chk("R9 valid", addr_valid, 1);
    chk("R9 addr", addr_out, 16'hC35A);
    @(negedge clk);
    chk("R9 single pulse", addr_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) regs[i] = 8'(i * 3 + 1);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();

    t_direct(8'hF3, 8'hD4);
    t_direct(8'h00, 8'hFF);

    t_indexed(8'h12, 8'hF0, 8'h20, 16'h1310);
    t_indexed(8'hFF, 8'hFF, 8'h01, 16'h0000);
    t_indexed(8'h40, 8'h00, 8'hFF, 16'h40FF);

    t_indirect(7'd45, 8'h34, 8'h12, "R4");
    t_indirect(7'd0,  8'hCD, 8'hAB, "R5");

    t_rel(2'b00, 16'h1000, 8'h7F, 8'h00, 8'h00, 16'h107F, 1'b1, "R6 fwd");
    t_rel(2'b00, 16'h1000, 8'h80, 8'h00, 8'h00, 16'h0F80, 1'b1, "R6 back");
    t_rel(2'b11, 16'hFFF0, 8'h20, 8'h00, 8'h00, 16'h0010, 1'b1, "R6 wrap");
    t_rel(2'b01, 16'h2000, 8'h10, 8'h0C, 8'h04, 16'h2010, 1'b1, "R7 taken");
    t_rel(2'b01, 16'h2000, 8'h10, 8'h0C, 8'h03, 16'h2000, 1'b0, "R7 not");
    t_rel(2'b10, 16'h3000, 8'hF0, 8'h0C, 8'h04, 16'h2FF0, 1'b1, "R8 taken");
    t_rel(2'b10, 16'h3000, 8'hF0, 8'h0C, 8'h0C, 16'h3000, 1'b0, "R8 not");

    t_busy_ignore();

    @(negedge clk);
    chk("R10 hold after idle", addr_out, 16'hC35A);
    chk("R10 take held", take_branch, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule